// File: doc/BRIEF.md
# Memory Sector CRC Sequencer

This block runs a checksum over a contiguous span of memory with no work from the processor. Software writes a starting page index and a sector count, sets an enable bit, and then writes the control register to start the run. Each sector is 1024 bytes, so the run begins at byte address page × 1024 and covers count × 1024 bytes.

During the run the sequencer reads memory one byte at a time in ascending address order through a synchronous read port that has one cycle of latency. It hands each byte to an external CRC engine over a valid/ready byte handshake, and it holds a stall output high so the processor waits. A small buffer absorbs the read latency and any backpressure from the engine, so with the engine always ready a new read is issued every cycle.

The CRC engine must be set up and initialised before the run. The sequencer never resets it. When the last byte has been accepted the stall drops and a done flag rises. Software then clears the enable bit and reads the result from the engine's own port.

Top module: `crc_sector_seq`

## Requirements
- R1: After reset, stall_o, done_o, mem_rd_o and crc_valid_o are all low.
- R2: Register writes decode reg_addr_i as 0 = page index (low 7 bits of data), 1 = sector count (8 bits), 2 = enable (bit 0), 3 = control. A write to address 3 starts a run only while enable is 1. With enable 0, such a write has no effect on any output.
- R3: A run reads addresses page×1024, page×1024+1, … in ascending order, modulo 2^17. It issues exactly count×1024 reads.
- R4: Every byte read is delivered on crc_byte_o once, in address order. While crc_valid_o is high and crc_ready_i is low, crc_byte_o holds its value.
- R5: With crc_ready_i held high and a count of at least 1, a read is issued every cycle. stall_o stays high for exactly count×1024+2 cycles.
- R6: stall_o rises on the clock edge that samples the starting write. It stays high until the last byte is accepted. mem_rd_o and crc_valid_o are only high while stall_o is high.
- R7: done_o goes low when a run starts. It rises on the same edge at which stall_o falls, and stays high until the next start.
- R8: A count of zero holds stall_o high for one cycle, issues no reads, and sets done_o.
- R9: A control write during a run is ignored. Page or count writes during a run do not change the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | 8 | Register write data |
| mem_addr_o | output | 17 | Memory byte address |
| mem_rd_o | output | 1 | Memory read enable |
| mem_rdata_i | input | 8 | Read data, valid one cycle after mem_rd_o |
| crc_valid_o | output | 1 | Byte offered to the CRC engine |
| crc_byte_o | output | 8 | Byte for the CRC engine |
| crc_ready_i | input | 1 | CRC engine accepts the byte |
| stall_o | output | 1 | Processor stall, high while a run is active |
| done_o | output | 1 | Last run completed |

## Verification
Two things can fall in the same cycle: issuing a new read and handing the final buffered byte to the engine. Completion also races against a fresh control write. The bench throttles crc_ready_i randomly, so buffer refill, pops and the finishing edge collide at varying offsets. It also issues a control write and a page rewrite partway through a run. The delivered byte stream is compared with a pattern that the bench computes from the programmed start address, and the stall length is compared with count×1024+2 when the engine is always ready. After completion the bench confirms that no second run started.

// File: rtl/crc_seq_pkg.sv
`timescale 1ns/1ps
package crc_seq_pkg;
  localparam int REG_AW = 2;
  localparam logic [REG_AW-1:0] REG_PAGE = 2'd0;
  localparam logic [REG_AW-1:0] REG_CNT  = 2'd1;
  localparam logic [REG_AW-1:0] REG_AUTO = 2'd2;
  localparam logic [REG_AW-1:0] REG_CTRL = 2'd3;

  typedef enum logic {ST_IDLE, ST_RUN} seq_state_e;
endpackage

// File: rtl/crc_seq_regs.sv
`timescale 1ns/1ps
module crc_seq_regs
  import crc_seq_pkg::*;
#(
  parameter int PAGE_W = 7,
  parameter int CNT_W  = 8,
  parameter int DW     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              busy_i,
  output logic [PAGE_W-1:0] page_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              start_o
);
  logic [PAGE_W-1:0] page_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              auto_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q <= '0;
      cnt_q  <= '0;
      auto_q <= 1'b0;
    end else if (wr_i) begin
      unique case (addr_i)
        REG_PAGE: page_q <= wdata_i[PAGE_W-1:0];
        REG_CNT:  cnt_q  <= wdata_i[CNT_W-1:0];
        REG_AUTO: auto_q <= wdata_i[0];
        default:  ;
      endcase
    end
  end

  // control write: any data value triggers, gated by enable and idle
  assign start_o = wr_i && (addr_i == REG_CTRL) && auto_q && !busy_i;
  assign page_o  = page_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/crc_seq_addr_gen.sv
`timescale 1ns/1ps
module crc_seq_addr_gen #(
  parameter int PAGE_W    = 7,
  parameter int CNT_W     = 8,
  parameter int SECTOR_LG = 10,
  parameter int ADDR_W    = PAGE_W + SECTOR_LG,
  parameter int REM_W     = CNT_W + SECTOR_LG
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              issue_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              rem_zero_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [REM_W-1:0]  rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      rem_q  <= '0;
    end else if (start_i) begin
      addr_q <= {page_i, {SECTOR_LG{1'b0}}};
      rem_q  <= {cnt_i, {SECTOR_LG{1'b0}}};
    end else if (issue_i) begin
      addr_q <= addr_q + ADDR_W'(1);
      rem_q  <= rem_q - REM_W'(1);
    end
  end

  assign addr_o     = addr_q;
  assign rem_zero_o = (rem_q == '0);
endmodule

// File: rtl/crc_seq_fifo.sv
`timescale 1ns/1ps
module crc_seq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 2,
  parameter int PTR_W = $clog2(DEPTH),
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [W-1:0]     din_i,
  input  logic             pop_i,
  output logic [W-1:0]     dout_o,
  output logic             empty_o,
  output logic [LVL_W-1:0] level_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [LVL_W-1:0] level_q;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      if (push_i) wr_ptr_q <= bump(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= bump(rd_ptr_q);
      unique case ({push_i, pop_i})
        2'b10:   level_q <= level_q + LVL_W'(1);
        2'b01:   level_q <= level_q - LVL_W'(1);
        default: ;
      endcase
    end
  end

  assign dout_o  = mem_q[rd_ptr_q];
  assign empty_o = (level_q == '0);
  assign level_o = level_q;
endmodule

// File: rtl/crc_sector_seq.sv
`timescale 1ns/1ps
module crc_sector_seq
  import crc_seq_pkg::*;
#(
  parameter int PAGE_W     = 7,
  parameter int CNT_W      = 8,
  parameter int SECTOR_LG  = 10,
  parameter int DW         = 8,
  parameter int FIFO_DEPTH = 2,
  parameter int ADDR_W     = PAGE_W + SECTOR_LG
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  input  logic [DW-1:0]     mem_rdata_i,
  output logic              crc_valid_o,
  output logic [DW-1:0]     crc_byte_o,
  input  logic              crc_ready_i,
  output logic              stall_o,
  output logic              done_o
);
  localparam int REM_W = CNT_W + SECTOR_LG;
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

  seq_state_e        state_q;
  logic              inflight_q, done_q;
  logic              busy, start, issue, pop, empty, rem_zero, room, drain_ok, finish;
  logic [PAGE_W-1:0] page;
  logic [CNT_W-1:0]  cnt;
  logic [LVL_W-1:0]  level;

  assign busy = (state_q == ST_RUN);

  crc_seq_regs #(.PAGE_W(PAGE_W), .CNT_W(CNT_W), .DW(DW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (reg_wr_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .busy_i  (busy),
    .page_o  (page),
    .cnt_o   (cnt),
    .start_o (start)
  );

  crc_seq_addr_gen #(
    .PAGE_W(PAGE_W), .CNT_W(CNT_W), .SECTOR_LG(SECTOR_LG),
    .ADDR_W(ADDR_W), .REM_W(REM_W)
  ) u_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .page_i     (page),
    .cnt_i      (cnt),
    .issue_i    (issue),
    .addr_o     (mem_addr_o),
    .rem_zero_o (rem_zero)
  );

  crc_seq_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (inflight_q),
    .din_i   (mem_rdata_i),
    .pop_i   (pop),
    .dout_o  (crc_byte_o),
    .empty_o (empty),
    .level_o (level)
  );

  assign crc_valid_o = !empty;
  assign pop         = !empty && crc_ready_i;
  // credit: buffered + in flight, less this cycle's pop, must leave a slot
  assign room     = (int'(level) + int'(inflight_q)) < (FIFO_DEPTH + int'(pop));
  assign issue    = busy && !rem_zero && room;
  assign drain_ok = empty || ((level == LVL_W'(1)) && pop);
  assign finish   = busy && rem_zero && !inflight_q && drain_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      inflight_q <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      inflight_q <= issue;
      if (start) begin
        state_q <= ST_RUN;
        done_q  <= 1'b0;
      end else if (finish) begin
        state_q <= ST_IDLE;
        done_q  <= 1'b1;
      end
    end
  end

  assign mem_rd_o = issue;
  assign stall_o  = busy;
  assign done_o   = done_q;
endmodule

// File: rtl/crc_seq_chk.sv
`timescale 1ns/1ps
module crc_seq_chk #(
  parameter int ADDR_W = 17,
  parameter int DW     = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_rd_o,
  input logic              crc_valid_o,
  input logic [DW-1:0]     crc_byte_o,
  input logic              crc_ready_i,
  input logic              stall_o,
  input logic              done_o
);
  assert_rd_in_stall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> stall_o);

  assert_valid_in_stall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_valid_o |-> stall_o);

  assert_byte_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (crc_valid_o && !crc_ready_i) |=> (crc_valid_o && $stable(crc_byte_o)));

  assert_addr_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o && $past(mem_rd_o)) |-> (mem_addr_o == ADDR_W'($past(mem_addr_o) + 1'b1)));

  assert_done_low_in_run_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> !done_o);

  assert_done_at_end_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stall_o) |-> done_o);
endmodule

bind crc_sector_seq crc_seq_chk #(.ADDR_W(ADDR_W), .DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mem_addr_o  (mem_addr_o),
  .mem_rd_o    (mem_rd_o),
  .crc_valid_o (crc_valid_o),
  .crc_byte_o  (crc_byte_o),
  .crc_ready_i (crc_ready_i),
  .stall_o     (stall_o),
  .done_o      (done_o)
);

// File: tb/crc_sector_seq_tb.sv
`timescale 1ns/1ps
module crc_sector_seq_tb;
  localparam int AW = 17;
  localparam int SEC = 1024;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [1:0]    reg_addr = '0;
  logic [7:0]    reg_wdata = '0;
  logic [AW-1:0] mem_addr;
  logic          mem_rd;
  logic [7:0]    mem_rdata = '0;
  logic          crc_valid;
  logic [7:0]    crc_byte;
  logic          crc_ready = 1'b1;
  logic          stall, done;

  int checks = 0, errors = 0;
  int got = 0, mism = 0, rd_cnt = 0, stall_cyc = 0;
  logic [AW-1:0] exp_addr = '0;
  bit rnd_ready = 1'b0;

  always #2.5 clk = ~clk;

  crc_sector_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .mem_addr_o(mem_addr), .mem_rd_o(mem_rd),
    .mem_rdata_i(mem_rdata), .crc_valid_o(crc_valid), .crc_byte_o(crc_byte),
    .crc_ready_i(crc_ready), .stall_o(stall), .done_o(done)
  );

  function automatic logic [7:0] pat(input logic [AW-1:0] a);
    return a[7:0] ^ (a[15:8] * 8'd29) ^ {a[16], 7'd0} ^ 8'h3C;
  endfunction

  // synchronous memory, one cycle latency
  always @(posedge clk) if (mem_rd) mem_rdata <= pat(mem_addr);

  // monitors
  always @(posedge clk) begin
    if (rst_n) begin
      if (stall) stall_cyc++;
      if (mem_rd) rd_cnt++;
      if (crc_valid && crc_ready) begin
        if (crc_byte !== pat(exp_addr)) mism++;
        exp_addr = exp_addr + 1'b1;
        got++;
      end
    end
  end

  always @(negedge clk) crc_ready <= rnd_ready ? (($urandom % 10) < 6) : 1'b1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic clear_mon(input logic [AW-1:0] start);
    got = 0; mism = 0; rd_cnt = 0; stall_cyc = 0; exp_addr = start;
  endtask

  task automatic run_start(input int page, input int cnt, input bit rnd);
    rnd_ready = rnd;
    reg_write(2'd0, 8'(page));
    reg_write(2'd1, 8'(cnt));
    reg_write(2'd2, 8'd1);
    clear_mon({7'(page), 10'd0});
    reg_write(2'd3, 8'h00);
    chk(stall === 1'b1, "R6", "stall after trigger", stall, 1);
    chk(done === 1'b0, "R7", "done cleared at start", done, 0);
  endtask

  task automatic run_finish(input int cnt, input bit rnd);
    while (stall) @(negedge clk);
    chk(got == cnt * SEC, "R4", "bytes delivered", got, cnt * SEC);
    chk(mism == 0, "R4", "byte order/content mismatches", mism, 0);
    chk(rd_cnt == cnt * SEC, "R3", "reads issued", rd_cnt, cnt * SEC);
    chk(done === 1'b1, "R7", "done after run", done, 1);
    if (!rnd && cnt > 0)
      chk(stall_cyc == cnt * SEC + 2, "R5", "stall cycles at full rate",
          stall_cyc, cnt * SEC + 2);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(stall === 1'b0 && done === 1'b0, "R1", "stall/done in reset", {stall, done}, 0);
    chk(mem_rd === 1'b0 && crc_valid === 1'b0, "R1", "rd/valid in reset", {mem_rd, crc_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(stall === 1'b0 && done === 1'b0, "R1", "state after reset", {stall, done}, 0);

    // R2: trigger with enable clear does nothing
    reg_write(2'd0, 8'd4);
    reg_write(2'd1, 8'd1);
    reg_write(2'd2, 8'd0);
    clear_mon('0);
    reg_write(2'd3, 8'hFF);
    repeat (6) @(negedge clk);
    chk(stall_cyc == 0 && rd_cnt == 0, "R2", "run without enable", stall_cyc + rd_cnt, 0);
    chk(done === 1'b0, "R2", "done without enable", done, 0);

    // R8: zero count
    run_start(12, 0, 1'b0);
    @(negedge clk);
    chk(stall === 1'b0, "R8", "stall length zero count", stall, 0);
    chk(stall_cyc == 1, "R8", "stall cycles zero count", stall_cyc, 1);
    chk(rd_cnt == 0, "R8", "reads zero count", rd_cnt, 0);
    chk(done === 1'b1, "R8", "done zero count", done, 1);

    // R3 R4 R5: full rate one sector
    run_start(3, 1, 1'b0);
    run_finish(1, 1'b0);
    repeat (4) @(negedge clk);
    chk(done === 1'b1 && stall === 1'b0, "R7", "done holds until next start", done, 1);

    // full rate two sectors
    run_start(40, 2, 1'b0);
    run_finish(2, 1'b0);

    // R9: retrigger and page rewrite during run
    run_start(5, 1, 1'b1);
    repeat (100) @(negedge clk);
    reg_write(2'd0, 8'd9);
    reg_write(2'd1, 8'd3);
    reg_write(2'd3, 8'h00);
    run_finish(1, 1'b1);
    chk(got == SEC, "R9", "run unchanged by mid-run writes", got, SEC);
    repeat (6) @(negedge clk);
    chk(stall === 1'b0 && rd_cnt == SEC, "R9", "no second run from ignored trigger", rd_cnt, SEC);

    // R3: wrap at top of address space
    run_start(127, 2, 1'b1);
    run_finish(2, 1'b1);
    chk(exp_addr == AW'(SEC), "R3", "address wrap end point", exp_addr, SEC);

    // random runs with throttled engine
    for (int i = 0; i < 6; i++) begin
      int pg, ct;
      pg = int'($urandom % 128);
      ct = 1 + int'($urandom % 3);
      run_start(pg, ct, 1'b1);
      run_finish(ct, 1'b1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule